// File: doc/BRIEF.md
# Integer ALU with Immediate Operand Forms

This block is the arithmetic and logic stage of a 32-bit load/store integer datapath. Every cycle it takes an operation code, two register operands, a 16-bit immediate and a 5-bit immediate. It returns a 32-bit result with no clock and no state. It covers wrapping add and subtract, bitwise logic, compares that write a 0/1 word, shifts and rotates. The instruction decoder upstream picks the operation and routes the immediate fields. The block only forms the second operand and selects the result.

Each immediate operation applies one fixed extension rule:
- Arithmetic immediates are sign-extended.
- Logic immediates are zero-extended.
- The high-half logic forms place the immediate in the upper 16 bits and put zeros below it.

Compares raise no flags. They write 1 or 0 into the whole result word. Inside the block, a decoder turns the operation code into a small bundle of strobes. A datapath then builds the operand, runs the adder, the logic unit, the comparator and a logarithmic shifter, and selects one result.

Top module: `int_alu`

## Requirements
- R1: Operation code 0 gives srcA + srcB and code 1 gives srcA - srcB, both modulo 2^32 with no overflow indication.
- R2: Codes 8, 9 and 10 give srcA AND, OR and XOR with the zero-extended immediate, so bits 31..16 of that operand are 0.
- R3: Codes 11, 12 and 13 give srcA AND, OR and XOR with the operand {imm16, 16'h0000}, so for code 11 bits 15..0 of the result are 0.
- R4: Codes 14 to 23 compare srcA with srcB and return exactly 1 when the condition holds and 0 otherwise. The conditions in code order are: equal, not equal, signed less, signed less-or-equal, signed greater, signed greater-or-equal, unsigned less, unsigned less-or-equal, unsigned greater, unsigned greater-or-equal.
- R5: Codes 6 and 7 give srcA plus and minus the sign-extended 16-bit immediate.
- R6: The register shift and rotate codes (24 to 28) take their amount from srcB bits 4..0 only. The immediate codes (29 to 33) take it from imm5. An amount of 0 returns srcA unchanged.
- R7: Code 24 (and 29) is a left shift that fills with zeros. Code 25 (and 30) is a logical right shift that fills with zeros. Code 26 (and 31) is an arithmetic right shift that copies bit 31 into the vacated bits.
- R8: Code 27 (and 32) rotates srcA left and code 28 (and 33) rotates it right, and no bit is lost.
- R9: Any operation code from 34 to 63 gives a result of 0.
- R10: Codes 2, 3, 4 and 5 give srcA AND, OR, XOR and NOR srcB, where NOR is the bitwise inverse of the OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 6 | Operation code, see requirements |
| srcA | input | 32 | First register operand |
| srcB | input | 32 | Second register operand, and register shift amount in bits 4..0 |
| imm16 | input | 16 | 16-bit immediate field |
| imm5 | input | 5 | Immediate shift or rotate amount |
| result | output | 32 | Computed result |

## Verification
The bench goes after the edges where extension and comparison go wrong. If an immediate of 0x8000 were sign-extended for the logic forms, it would set the upper 16 bits. If it were zero-extended for add-immediate, it would add +32768 instead of subtracting. Compares are driven at 0x80000000 against 0x7FFFFFFF. Here a design that mixes up signed and unsigned order returns the opposite bit, and an equal pair separates less from less-or-equal. Shift amounts of 0 and 31 are applied, along with register amounts that have bits above 4 set. These expose a sign fill missing from the arithmetic shift, a rotate that drops bits, and a shifter that reads the full srcB as the amount.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [5:0] {
    OP_ADD   = 6'd0,  OP_SUB   = 6'd1,  OP_AND   = 6'd2,  OP_OR    = 6'd3,
    OP_XOR   = 6'd4,  OP_NOR   = 6'd5,  OP_ADDI  = 6'd6,  OP_SUBI  = 6'd7,
    OP_ANDI  = 6'd8,  OP_ORI   = 6'd9,  OP_XORI  = 6'd10, OP_ANDHI = 6'd11,
    OP_ORHI  = 6'd12, OP_XORHI = 6'd13, OP_CEQ   = 6'd14, OP_CNE   = 6'd15,
    OP_CLT   = 6'd16, OP_CLE   = 6'd17, OP_CGT   = 6'd18, OP_CGE   = 6'd19,
    OP_CLTU  = 6'd20, OP_CLEU  = 6'd21, OP_CGTU  = 6'd22, OP_CGEU  = 6'd23,
    OP_SLL   = 6'd24, OP_SRL   = 6'd25, OP_SRA   = 6'd26, OP_ROL   = 6'd27,
    OP_ROR   = 6'd28, OP_SLLI  = 6'd29, OP_SRLI  = 6'd30, OP_SRAI  = 6'd31,
    OP_ROLI  = 6'd32, OP_RORI  = 6'd33
  } aluOp_e;

  localparam int OP_LAST = 33;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT, OPB_HIGH
  } opbSel_e;

  typedef enum logic [2:0] {
    UNIT_NONE, UNIT_ADD, UNIT_LOGIC, UNIT_CMP, UNIT_SHIFT
  } unit_e;

  typedef enum logic [1:0] {
    LG_AND, LG_OR, LG_XOR, LG_NOR
  } logicOp_e;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LT, CMP_LE, CMP_GT, CMP_GE
  } cmpKind_e;

  typedef enum logic [2:0] {
    SH_LL, SH_RL, SH_RA, SH_ROL, SH_ROR
  } shKind_e;

  typedef struct packed {
    opbSel_e  opbSel;
    unit_e    unit;
    logic     subtract;
    logicOp_e logicOp;
    cmpKind_e cmpKind;
    logic     cmpUnsigned;
    shKind_e  shKind;
    logic     amtFromImm;
  } aluStrobes_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [5:0]  opSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes             = '0;
    strobes.opbSel      = OPB_REG;
    strobes.unit        = UNIT_NONE;
    strobes.logicOp     = LG_AND;
    strobes.cmpKind     = CMP_EQ;
    strobes.shKind      = SH_LL;
    case (opSel)
      OP_ADD:   strobes.unit = UNIT_ADD;
      OP_SUB:   begin strobes.unit = UNIT_ADD; strobes.subtract = 1'b1; end
      OP_ADDI:  begin strobes.unit = UNIT_ADD; strobes.opbSel = OPB_SEXT; end
      OP_SUBI:  begin
        strobes.unit = UNIT_ADD; strobes.opbSel = OPB_SEXT; strobes.subtract = 1'b1;
      end
      OP_AND:   begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_AND; end
      OP_OR:    begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_OR;  end
      OP_XOR:   begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_XOR; end
      OP_NOR:   begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_NOR; end
      OP_ANDI:  begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_AND; strobes.opbSel = OPB_ZEXT; end
      OP_ORI:   begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_OR;  strobes.opbSel = OPB_ZEXT; end
      OP_XORI:  begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_XOR; strobes.opbSel = OPB_ZEXT; end
      OP_ANDHI: begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_AND; strobes.opbSel = OPB_HIGH; end
      OP_ORHI:  begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_OR;  strobes.opbSel = OPB_HIGH; end
      OP_XORHI: begin strobes.unit = UNIT_LOGIC; strobes.logicOp = LG_XOR; strobes.opbSel = OPB_HIGH; end
      OP_CEQ:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_EQ; end
      OP_CNE:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_NE; end
      OP_CLT:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_LT; end
      OP_CLE:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_LE; end
      OP_CGT:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_GT; end
      OP_CGE:   begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_GE; end
      OP_CLTU:  begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_LT; strobes.cmpUnsigned = 1'b1; end
      OP_CLEU:  begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_LE; strobes.cmpUnsigned = 1'b1; end
      OP_CGTU:  begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_GT; strobes.cmpUnsigned = 1'b1; end
      OP_CGEU:  begin strobes.unit = UNIT_CMP; strobes.cmpKind = CMP_GE; strobes.cmpUnsigned = 1'b1; end
      OP_SLL:   begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_LL;  end
      OP_SRL:   begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_RL;  end
      OP_SRA:   begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_RA;  end
      OP_ROL:   begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_ROL; end
      OP_ROR:   begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_ROR; end
      OP_SLLI:  begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_LL;  strobes.amtFromImm = 1'b1; end
      OP_SRLI:  begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_RL;  strobes.amtFromImm = 1'b1; end
      OP_SRAI:  begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_RA;  strobes.amtFromImm = 1'b1; end
      OP_ROLI:  begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_ROL; strobes.amtFromImm = 1'b1; end
      OP_RORI:  begin strobes.unit = UNIT_SHIFT; strobes.shKind = SH_ROR; strobes.amtFromImm = 1'b1; end
      default:  strobes.unit = UNIT_NONE;
    endcase
  end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] dataIn,
  input  logic [SHW-1:0]  amount,
  input  shKind_e         kind,
  output logic [XLEN-1:0] dataOut
);

  for (genvar g = 0; g < SHW; g++) begin : stg
    localparam int D = 1 << g;
    logic [XLEN-1:0] prev;
    logic [XLEN-1:0] next;

    if (g == 0) begin : gFirst
      assign prev = dataIn;
    end else begin : gChain
      assign prev = stg[g-1].next;
    end

    always_comb begin
      next = prev;
      if (amount[g]) begin
        case (kind)
          SH_LL:   next = {prev[XLEN-1-D:0], {D{1'b0}}};
          SH_RL:   next = {{D{1'b0}}, prev[XLEN-1:D]};
          SH_RA:   next = {{D{prev[XLEN-1]}}, prev[XLEN-1:D]};
          SH_ROL:  next = {prev[XLEN-1-D:0], prev[XLEN-1:XLEN-D]};
          SH_ROR:  next = {prev[D-1:0], prev[XLEN-1:D]};
          default: next = prev;
        endcase
      end
    end
  end

  assign dataOut = stg[SHW-1].next;

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN),
  localparam int PADW = XLEN - IMMW
) (
  input  aluStrobes_t     strobes,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [IMMW-1:0] imm16,
  input  logic [SHW-1:0]  imm5,
  output logic [XLEN-1:0] result
);

  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] sumOut;
  logic [XLEN-1:0] logicOut;
  logic [XLEN-1:0] cmpOut;
  logic [XLEN-1:0] shiftOut;
  logic [SHW-1:0]  shAmt;
  logic            isEq;
  logic            isLess;
  logic            cmpHit;

  always_comb begin
    case (strobes.opbSel)
      OPB_SEXT: opB = {{PADW{imm16[IMMW-1]}}, imm16};
      OPB_ZEXT: opB = {{PADW{1'b0}}, imm16};
      OPB_HIGH: opB = {imm16, {PADW{1'b0}}};
      default:  opB = srcB;
    endcase
  end

  assign sumOut = srcA + (strobes.subtract ? ~opB : opB) + XLEN'(strobes.subtract);

  always_comb begin
    case (strobes.logicOp)
      LG_AND:  logicOut = srcA & opB;
      LG_OR:   logicOut = srcA | opB;
      LG_XOR:  logicOut = srcA ^ opB;
      default: logicOut = ~(srcA | opB);
    endcase
  end

  assign isEq   = (srcA == opB);
  assign isLess = strobes.cmpUnsigned ? (srcA < opB) : ($signed(srcA) < $signed(opB));

  always_comb begin
    case (strobes.cmpKind)
      CMP_EQ:  cmpHit = isEq;
      CMP_NE:  cmpHit = !isEq;
      CMP_LT:  cmpHit = isLess;
      CMP_LE:  cmpHit = isLess || isEq;
      CMP_GT:  cmpHit = !(isLess || isEq);
      default: cmpHit = !isLess;
    endcase
  end

  assign cmpOut = {{(XLEN-1){1'b0}}, cmpHit};
  assign shAmt  = strobes.amtFromImm ? imm5 : srcB[SHW-1:0];

  int_alu_shifter #(.XLEN(XLEN)) u_shifter (
    .dataIn  (srcA),
    .amount  (shAmt),
    .kind    (strobes.shKind),
    .dataOut (shiftOut)
  );

  always_comb begin
    case (strobes.unit)
      UNIT_ADD:   result = sumOut;
      UNIT_LOGIC: result = logicOut;
      UNIT_CMP:   result = cmpOut;
      UNIT_SHIFT: result = shiftOut;
      default:    result = '0;
    endcase
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [5:0]      opSel,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [IMMW-1:0] imm16,
  input  logic [SHW-1:0]  imm5,
  output logic [XLEN-1:0] result
);

  aluStrobes_t strobes;

  int_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  int_alu_datapath #(.XLEN(XLEN), .IMMW(IMMW)) u_datapath (
    .strobes (strobes),
    .srcA    (srcA),
    .srcB    (srcB),
    .imm16   (imm16),
    .imm5    (imm5),
    .result  (result)
  );

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input logic [5:0]      opSel,
  input logic [XLEN-1:0] srcA,
  input logic [XLEN-1:0] srcB,
  input logic [IMMW-1:0] imm16,
  input logic [SHW-1:0]  imm5,
  input logic [XLEN-1:0] result
);

  logic isShift;
  logic zeroAmt;

  assign isShift = (opSel >= 6'd24) && (opSel <= 6'd33);
  assign zeroAmt = (opSel <= 6'd28) ? (srcB[SHW-1:0] == '0) : (imm5 == '0);

  always_comb begin
    if ((opSel >= 6'd14) && (opSel <= 6'd23)) begin
      // R4
      cmp_bool_chk: assert (result[XLEN-1:1] == '0)
        else $error("compare result wider than one bit: %h", result);
    end
    if (opSel > 6'(OP_LAST)) begin
      // R9
      bad_op_zero_chk: assert (result == '0)
        else $error("unsupported code %0d gave %h", opSel, result);
    end
    if (isShift && zeroAmt) begin
      // R6
      zero_amt_pass_chk: assert (result == srcA)
        else $error("zero amount changed operand: %h vs %h", result, srcA);
    end
    if (opSel == 6'd8) begin
      // R2
      zext_upper_chk: assert (result[XLEN-1:IMMW] == '0)
        else $error("zero-extended and leaked upper bits: %h", result);
    end
    if (opSel == 6'd11) begin
      // R3
      high_lower_chk: assert (result[XLEN-IMMW-1:0] == '0)
        else $error("high-half and left lower bits: %h", result);
    end
    if (((opSel == 6'd25) && (srcB[SHW-1:0] != '0)) || ((opSel == 6'd30) && (imm5 != '0))) begin
      // R7
      srl_msb_zero_chk: assert (result[XLEN-1] == 1'b0)
        else $error("logical right shift kept top bit: %h", result);
    end
  end

endmodule

bind int_alu int_alu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (.*);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;

  logic        clk = 1'b0;
  logic [5:0]  opSel = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  imm5 = '0;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int_alu u_int_alu (
    .opSel  (opSel),
    .srcA   (srcA),
    .srcB   (srcB),
    .imm16  (imm16),
    .imm5   (imm5),
    .result (result)
  );

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v << n) | (v >> (32 - n)));
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] i,
                                        input logic [4:0] s);
    logic [31:0] sx, zx, hi;
    int rb, ri;
    sx = {{16{i[15]}}, i};
    zx = {16'h0, i};
    hi = {i, 16'h0};
    rb = int'(b[4:0]);
    ri = int'(s);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a & b;
      3:  return a | b;
      4:  return a ^ b;
      5:  return ~(a | b);
      6:  return a + sx;
      7:  return a - sx;
      8:  return a & zx;
      9:  return a | zx;
      10: return a ^ zx;
      11: return a & hi;
      12: return a | hi;
      13: return a ^ hi;
      14: return {31'b0, a == b};
      15: return {31'b0, a != b};
      16: return {31'b0, $signed(a) <  $signed(b)};
      17: return {31'b0, $signed(a) <= $signed(b)};
      18: return {31'b0, $signed(a) >  $signed(b)};
      19: return {31'b0, $signed(a) >= $signed(b)};
      20: return {31'b0, a <  b};
      21: return {31'b0, a <= b};
      22: return {31'b0, a >  b};
      23: return {31'b0, a >= b};
      24: return a << rb;
      25: return a >> rb;
      26: return 32'($signed(a) >>> rb);
      27: return rotl(a, rb);
      28: return rotr(a, rb);
      29: return a << ri;
      30: return a >> ri;
      31: return 32'($signed(a) >>> ri);
      32: return rotl(a, ri);
      33: return rotr(a, ri);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input int op);
    if (op <= 1) return "R1";
    if (op <= 5) return "R10";
    if (op <= 7) return "R5";
    if (op <= 10) return "R2";
    if (op <= 13) return "R3";
    if (op <= 23) return "R4";
    if (op == 27 || op == 28 || op == 32 || op == 33) return "R8";
    if (op <= 33) return "R7";
    return "R9";
  endfunction

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, input logic [4:0] s, input string tag);
    logic [31:0] exp;
    @(posedge clk);
    opSel = 6'(op);
    srcA  = a;
    srcB  = b;
    imm16 = i;
    imm5  = s;
    exp   = model(op, a, b, i, s);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h imm16=%h imm5=%0d actual=%h expected=%h",
               tag, op, a, b, i, s, result, exp);
    end
  endtask

  initial begin
    // Idle state with all inputs zero: code 0 must give 0 (R1)
    @(negedge clk);
    checks++;
    if (result !== 32'h0) begin
      fails++;
      $display("FAIL R1 idle actual=%h expected=%h", result, 32'h0);
    end

    // R1 wrap
    apply(0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, "R1");
    apply(1, 32'h0, 32'h1, 16'h0, 5'd0, "R1");
    apply(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R1");
    // R5 sign extension
    apply(6, 32'h0000_0010, 32'h0, 16'h8000, 5'd0, "R5");
    apply(7, 32'h0, 32'h0, 16'hFFFF, 5'd0, "R5");
    apply(6, 32'h1, 32'h0, 16'h7FFF, 5'd0, "R5");
    // R2 zero extension
    apply(8, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, "R2");
    apply(9, 32'h0, 32'h0, 16'hFFFF, 5'd0, "R2");
    apply(10, 32'hFFFF_0000, 32'h0, 16'h8000, 5'd0, "R2");
    // R3 high half
    apply(11, 32'hFFFF_FFFF, 32'h0, 16'h1234, 5'd0, "R3");
    apply(12, 32'h0000_5678, 32'h0, 16'hABCD, 5'd0, "R3");
    apply(13, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, "R3");
    // R10
    apply(5, 32'hF0F0_0000, 32'h0F0F_0000, 16'h0, 5'd0, "R10");
    apply(2, 32'hDEAD_BEEF, 32'hFFFF_0000, 16'h0, 5'd0, "R10");
    // R4 boundaries
    for (int op = 14; op <= 23; op++) begin
      apply(op, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, "R4");
      apply(op, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, "R4");
      apply(op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, "R4");
    end
    // R6 amount source and zero amount
    apply(24, 32'h1234_5678, 32'hFFFF_FFE0, 16'h0, 5'd7, "R6");
    apply(26, 32'h8000_0001, 32'h0000_0021, 16'h0, 5'd0, "R6");
    apply(29, 32'hCAFE_F00D, 32'h0000_001F, 16'h0, 5'd0, "R6");
    apply(32, 32'hCAFE_F00D, 32'h0, 16'h0, 5'd0, "R6");
    // R7 extremes
    apply(26, 32'h8000_0000, 32'd31, 16'h0, 5'd0, "R7");
    apply(25, 32'h8000_0000, 32'd31, 16'h0, 5'd0, "R7");
    apply(31, 32'h8765_4321, 32'h0, 16'h0, 5'd4, "R7");
    apply(24, 32'hFFFF_FFFF, 32'd31, 16'h0, 5'd0, "R7");
    // R8 rotates
    apply(27, 32'h8000_0001, 32'd1, 16'h0, 5'd0, "R8");
    apply(28, 32'h8000_0001, 32'd1, 16'h0, 5'd0, "R8");
    apply(33, 32'h1234_5678, 32'h0, 16'h0, 5'd31, "R8");
    apply(32, 32'h1234_5678, 32'h0, 16'h0, 5'd16, "R8");
    // R9 unsupported
    apply(34, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, "R9");
    apply(63, 32'hFFFF_FFFF, 32'h1, 16'h1, 5'd1, "R9");

    // Random mix across every code, fixed seed
    void'($urandom(32'd7351));
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [31:0] a, b;
      op = int'($urandom_range(0, 40));
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 7) == 0) a = 32'h8000_0000;
      if ($urandom_range(0, 7) == 0) b = a;
      apply(op, a, b, 16'($urandom()), 5'($urandom()), reqOf(op));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule